// File: doc/BRIEF.md
# Nibble-Wide Ethernet Transmit Framer with Carrier Deferral

This block turns a frame image held in a byte buffer into a complete Ethernet frame on a 4-bit media-independent transmit interface. The buffer holds only the two addresses, the type/length field and the payload. The framer puts the preamble and start delimiter in front of them. It appends zero bytes when the frame is short and closes the frame with a 32-bit CRC. One clock cycle carries one nibble. The buffer is read through an asynchronous read port addressed by the framer. The pointer to the last valid byte is captured when a start command is accepted.

In half-duplex operation the framer holds off while carrier sense shows a busy medium. A collision aborts the frame and raises a flag for external retry logic. If carrier drops part way through a frame, a flag is raised but the frame still completes. In full-duplex operation both carrier sense and collision are disregarded. In every mode a minimum quiet time of 24 nibble times separates frames. A sticky completion flag, qualified by an enable, forms the interrupt output.

States: IDLE (waiting for a start), WAIT (start accepted, waiting for a quiet line), PRE (preamble and delimiter), BODY (buffer bytes), PAD (zero fill), FCS (CRC nibbles). Transitions:
- IDLE goes to WAIT on start.
- WAIT goes to PRE when the gap is met and the line is clear.
- PRE goes to BODY after 16 nibbles.
- BODY goes to PAD after the last buffer byte if fewer than 60 bytes have been sent. Otherwise BODY goes to FCS.
- PAD goes to FCS once byte 59 is done.
- FCS goes to IDLE after 8 nibbles.
- Any transmitting state goes to IDLE on a half-duplex collision.

Top module: `mii_tx_framer`

## Requirements
- R1: After reset tx_en, busy, done, aborted, cs_lost and irq are all low.
- R2: A frame opens with 15 nibbles of 0x5 followed by one nibble 0xD (seven 0x55 bytes then 0xD5). tx_en is high from the first of these nibbles through the last CRC nibble, and low otherwise.
- R3: Buffer bytes 0 to eof_ptr follow the delimiter in address order, each sent as bits 3:0 first and then bits 7:4.
- R4: When eof_ptr is below 59, zero bytes are inserted after the buffer bytes until 60 bytes (46 payload bytes) have been sent. With eof_ptr at 59 or above, no fill is added.
- R5: After the body and fill come four CRC bytes, sent low byte first, each byte low nibble first. The value is the complement of the reflected CRC-32 (polynomial 0xEDB88320, preset all ones), computed over every body and fill nibble taken LSB first.
- R6: tx_en rises only after at least 24 consecutive cycles in which tx_en was low and, in half-duplex, crs was low. The first preamble nibble appears the cycle after the clock edge at which that count is reached, the command is pending and crs is low. A start needs at least 2 cycles to reach tx_en.
- R7: With full_duplex high, crs affects neither deferral nor any status flag.
- R8: With full_duplex low, col high while tx_en is high drops tx_en on the next cycle and sets aborted, and done stays low. With full_duplex high, col is ignored.
- R9: In half-duplex, if crs has been seen high during the frame and is then low while tx_en is high, cs_lost is set when the frame completes. The frame is still sent in full.
- R10: done is set in the cycle after the last CRC nibble. irq equals done while irq_en is high. done, aborted and cs_lost are cleared when a start is accepted.
- R11: A start while busy is high is ignored. It neither changes the frame in progress nor queues another frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| full_duplex | input | 1 | 1: full-duplex, 0: half-duplex |
| irq_en | input | 1 | Completion interrupt enable |
| start | input | 1 | Start command, accepted in IDLE |
| eof_ptr | input | ADDR_W | Address of the last frame byte in the buffer |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_data | input | 8 | Buffer read data for buf_addr, same cycle |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| tx_en | output | 1 | Transmit enable |
| txd | output | 4 | Transmit nibble |
| busy | output | 1 | Command accepted and not yet finished |
| done | output | 1 | Sticky frame-complete flag |
| aborted | output | 1 | Sticky collision-abort flag |
| cs_lost | output | 1 | Sticky carrier-lost flag |
| irq | output | 1 | Completion interrupt |

## Verification
A start is taken at one edge, so busy is high one cycle later. The earliest first preamble nibble comes one cycle after that. A half-duplex collision takes tx_en low one cycle after the cycle in which col was seen. done, cs_lost and aborted change one cycle after the deciding edge, and irq follows done with no delay. The bench reference model advances on each rising edge from the inputs sampled there, in the same way as these latencies. It compares every output a quarter period after that edge, once all register outputs have settled. Frame length and gap length are measured as run lengths of tx_en and checked against the counts fixed by R4 and R6.

// File: rtl/mtf_pkg.sv
package mtf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_PRE,
        S_BODY,
        S_PAD,
        S_FCS
    } tx_state_e;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    // advance a reflected CRC-32 by four data bits, bit 0 first
    function automatic logic [31:0] crc_nibble(input logic [31:0] c_in, input logic [3:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 4; i++) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/mtf_gap_timer.sv
module mtf_gap_timer #(
    parameter int IFG = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_busy,
    output logic gap_met
);
    localparam int CW = (IFG > 2) ? $clog2(IFG) : 1;
    localparam logic [CW-1:0] TOP = CW'(IFG - 1);

    logic [CW-1:0] quiet_q;

    // counts quiet cycles, saturating one short of the gap;
    // the current quiet cycle completes the gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             quiet_q <= TOP;
        else if (line_busy)     quiet_q <= '0;
        else if (quiet_q < TOP) quiet_q <= quiet_q + 1'b1;
    end

    assign gap_met = (quiet_q == TOP) && !line_busy;

endmodule

// File: rtl/mtf_crc32.sv
module mtf_crc32
    import mtf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [3:0]  nib,
    output logic [31:0] crc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '1;
        else if (init) crc_q <= '1;
        else if (en)   crc_q <= crc_nibble(crc_q, nib);
    end
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
    import mtf_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PRE_BYTES   = 7,
    parameter int HDR_BYTES   = 14,
    parameter int MIN_DATA    = 46,
    parameter int IFG_NIBBLES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_duplex,
    input  logic              irq_en,
    input  logic              start,
    input  logic [ADDR_W-1:0] eof_ptr,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              crs,
    input  logic              col,
    output logic              tx_en,
    output logic [3:0]        txd,
    output logic              busy,
    output logic              done,
    output logic              aborted,
    output logic              cs_lost,
    output logic              irq
);
    localparam int MIN_FRAME = HDR_BYTES + MIN_DATA;
    localparam int PRE_NIB   = 2 * (PRE_BYTES + 1);
    localparam int PN_W      = $clog2(PRE_NIB);
    localparam int BI_W      = ADDR_W + 1;
    localparam int FCS_NIB   = 8;
    localparam int FN_W      = $clog2(FCS_NIB);

    tx_state_e state_q, state_d;

    logic [PN_W-1:0]   pre_idx;
    logic [BI_W-1:0]   byte_idx;
    logic              hi_nib;
    logic [FN_W-1:0]   fcs_idx;
    logic [ADDR_W-1:0] last_q;
    logic              crs_seen, lost_q;
    logic [31:0]       crc_q;
    logic              gap_met;

    logic tx_active, half_col, last_byte, need_pad, frame_end, line_busy;

    assign tx_active = (state_q == S_PRE) || (state_q == S_BODY) ||
                       (state_q == S_PAD) || (state_q == S_FCS);
    assign half_col  = !full_duplex && col && tx_active;
    assign last_byte = hi_nib && (byte_idx == {1'b0, last_q});
    assign need_pad  = byte_idx < BI_W'(MIN_FRAME - 1);
    assign frame_end = (state_q == S_FCS) && (fcs_idx == FN_W'(FCS_NIB - 1));
    assign line_busy = tx_active || (!full_duplex && crs);

    mtf_gap_timer #(.IFG(IFG_NIBBLES)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_busy (line_busy),
        .gap_met   (gap_met)
    );

    mtf_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (state_q == S_PRE),
        .en    ((state_q == S_BODY) || (state_q == S_PAD)),
        .nib   (txd),
        .crc_q (crc_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_WAIT;
            S_WAIT: if (gap_met) state_d = S_PRE;
            S_PRE:  if (pre_idx == PN_W'(PRE_NIB - 1)) state_d = S_BODY;
            S_BODY: if (last_byte) state_d = need_pad ? S_PAD : S_FCS;
            S_PAD:  if (hi_nib && byte_idx == BI_W'(MIN_FRAME - 1)) state_d = S_FCS;
            S_FCS:  if (frame_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (half_col) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_idx  <= '0;
            byte_idx <= '0;
            hi_nib   <= 1'b0;
            fcs_idx  <= '0;
            last_q   <= '0;
        end else begin
            if (state_q == S_IDLE && start) last_q <= eof_ptr;
            pre_idx <= (state_q == S_PRE) ? pre_idx + 1'b1 : '0;
            fcs_idx <= (state_q == S_FCS) ? fcs_idx + 1'b1 : '0;
            if (state_q == S_BODY || state_q == S_PAD) begin
                hi_nib <= ~hi_nib;
                if (hi_nib) byte_idx <= byte_idx + 1'b1;
            end else begin
                hi_nib   <= 1'b0;
                byte_idx <= '0;
            end
        end
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            aborted  <= 1'b0;
            cs_lost  <= 1'b0;
            crs_seen <= 1'b0;
            lost_q   <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                done     <= 1'b0;
                aborted  <= 1'b0;
                cs_lost  <= 1'b0;
                crs_seen <= 1'b0;
                lost_q   <= 1'b0;
            end
            if (tx_active && !full_duplex) begin
                if (crs)           crs_seen <= 1'b1;
                else if (crs_seen) lost_q   <= 1'b1;
            end
            if (half_col) begin
                aborted <= 1'b1;
            end else if (frame_end) begin
                done    <= 1'b1;
                cs_lost <= !full_duplex && (lost_q || (crs_seen && !crs));
            end
        end
    end

    // outputs
    always_comb begin
        tx_en    = tx_active;
        busy     = (state_q != S_IDLE);
        buf_addr = byte_idx[ADDR_W-1:0];
        irq      = done && irq_en;
        unique case (state_q)
            S_PRE:   txd = (pre_idx == PN_W'(PRE_NIB - 1)) ? 4'hD : 4'h5;
            S_BODY:  txd = hi_nib ? buf_data[7:4] : buf_data[3:0];
            S_FCS:   txd = ~crc_q[{fcs_idx, 2'b00} +: 4];
            default: txd = 4'h0;
        endcase
    end

endmodule

// File: rtl/mtf_checker.sv
module mtf_checker #(
    parameter int IFG = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       full_duplex,
    input logic       crs,
    input logic       col,
    input logic       tx_en,
    input logic [3:0] txd,
    input logic       done,
    input logic       aborted,
    input logic       cs_lost
);
    int quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          quiet_cnt <= IFG;
        else if (tx_en || (!full_duplex && crs)) quiet_cnt <= 0;
        else if (quiet_cnt < IFG)            quiet_cnt <= quiet_cnt + 1;
    end

    // R2
    preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 4'h5));

    // R6
    gap_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (quiet_cnt >= IFG));

    // R8
    collision_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && col && tx_en) |=> !tx_en);

    // R8
    abort_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted) |-> $past(!full_duplex && col && tx_en));

    // R10
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(tx_en));

    // R9
    lost_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_lost) |-> !full_duplex);

endmodule

bind mii_tx_framer mtf_checker #(.IFG(IFG_NIBBLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .crs         (crs),
    .col         (col),
    .tx_en       (tx_en),
    .txd         (txd),
    .done        (done),
    .aborted     (aborted),
    .cs_lost     (cs_lost)
);

// File: tb/mii_tx_framer_test.sv
module mii_tx_framer_test;
    localparam int CLK_P = 10;
    localparam int AW    = 11;
    localparam int GAP   = 24;

    logic clk = 1'b0;
    logic rst_n, full_duplex, irq_en, start;
    logic [AW-1:0] eof_ptr, buf_addr;
    logic [7:0] buf_data;
    logic crs, col;
    logic tx_en, busy, done, aborted, cs_lost, irq;
    logic [3:0] txd;

    logic [7:0] mem [0:(1<<AW)-1];
    assign buf_data = mem[buf_addr];

    always #(CLK_P/2) clk = ~clk;

    mii_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .irq_en(irq_en),
        .start(start), .eof_ptr(eof_ptr), .buf_addr(buf_addr), .buf_data(buf_data),
        .crs(crs), .col(col), .tx_en(tx_en), .txd(txd), .busy(busy), .done(done),
        .aborted(aborted), .cs_lost(cs_lost), .irq(irq)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    // ---------------- line stimulus: carrier and collision ----------------
    bit crs_echo = 0, crs_val = 0;
    int drop_at = 0, col_at = 0, tx_run = 0;

    always @(negedge clk) begin
        tx_run = tx_en ? tx_run + 1 : 0;
        if (crs_echo) crs <= tx_en && !(drop_at > 0 && tx_run >= drop_at);
        else          crs <= crs_val;
        col <= (col_at > 0) && (tx_run == col_at);
    end

    // ---------------- behavioural reference model ----------------
    int q[$];
    int tagq[$];
    bit pending, m_done, m_abort, m_lost_flag, seen, lost;
    int quiet, m_eof;

    task automatic build_frame(input int eof);
        int b[$];
        int bt[$];
        logic [31:0] c;
        int nbody;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 7; i++) begin b.push_back(8'h55); bt.push_back(2); end
        b.push_back(8'hD5); bt.push_back(2);
        nbody = (eof + 1 < 60) ? 60 : eof + 1;
        for (int i = 0; i < nbody; i++) begin
            logic [7:0] v;
            v = (i <= eof) ? mem[i] : 8'h00;
            b.push_back(int'(v)); bt.push_back((i <= eof) ? 3 : 4);
            c = c ^ {24'h0, v};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) begin b.push_back(int'(c[8*i +: 8])); bt.push_back(5); end
        foreach (b[i]) begin
            q.push_back(b[i] & 15);        tagq.push_back(bt[i]);
            q.push_back((b[i] >> 4) & 15); tagq.push_back(bt[i]);
        end
    endtask

    task automatic model_step();
        bit active, hd, launch;
        if (!rst_n) begin
            q.delete(); tagq.delete();
            pending = 0; m_done = 0; m_abort = 0; m_lost_flag = 0;
            seen = 0; lost = 0; quiet = GAP - 1; m_eof = 0;
            return;
        end
        active = q.size() > 0;
        hd     = !full_duplex;
        launch = pending && (quiet >= GAP - 1) && !(hd && crs);
        if (active || (hd && crs)) quiet = 0;
        else if (quiet < GAP - 1)  quiet++;
        if (active) begin
            if (hd && crs) seen = 1;
            else if (hd && seen) lost = 1;
            if (hd && col) begin
                q.delete(); tagq.delete();
                m_abort = 1;
            end else begin
                void'(q.pop_front()); void'(tagq.pop_front());
                if (q.size() == 0) begin
                    m_done = 1;
                    m_lost_flag = hd && lost;
                end
            end
        end else if (launch) begin
            pending = 0;
            build_frame(m_eof);
        end else if (!pending && start) begin
            pending = 1; m_eof = int'(eof_ptr);
            m_done = 0; m_abort = 0; m_lost_flag = 0; seen = 0; lost = 0;
        end
    endtask

    // run-length monitors
    int run_len = 0, last_len = 0, low_run = 0, last_gap = 0;
    bit prev_en = 0;

    always @(posedge clk) begin
        model_step();
        #(CLK_P/4);
        if (rst_n) begin
            // R2 tx_en framing, R6 launch timing
            check(tx_en === (q.size() > 0), (q.size() > 0) ? "R2" : "R6",
                  int'(tx_en), int'(q.size() > 0));
            if (q.size() > 0)
                check(txd === q[0][3:0], tag_name(tagq[0]), int'(txd), q[0]);
            check(done === m_done, "R10", int'(done), int'(m_done));
            check(aborted === m_abort, "R8", int'(aborted), int'(m_abort));
            check(cs_lost === m_lost_flag, "R9", int'(cs_lost), int'(m_lost_flag));
            check(irq === (m_done && irq_en), "R10", int'(irq), int'(m_done && irq_en));
            check(busy === (pending || q.size() > 0), "R11", int'(busy), int'(pending || q.size() > 0));
        end
        if (tx_en) begin
            if (!prev_en) begin last_gap = low_run; low_run = 0; end
            run_len++;
        end else begin
            if (prev_en) begin last_len = run_len; run_len = 0; end
            low_run++;
        end
        prev_en = tx_en;
    end

    // ---------------- stimulus helpers ----------------
    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) mem[i] = 8'((i * 37 + seed) & 255);
    endtask

    task automatic kick(input int eof);
        @(negedge clk); start = 1; eof_ptr = AW'(eof);
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        rst_n = 0; start = 0; eof_ptr = '0; full_duplex = 1; irq_en = 1;
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_en == 0, "R1", int'(tx_en), 0);
        check(busy == 0, "R1", int'(busy), 0);
        check(done == 0 && aborted == 0 && cs_lost == 0, "R1", int'({done, aborted, cs_lost}), 0);
        check(irq == 0, "R1", int'(irq), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // full duplex, short frame padded, carrier held high (R4, R7)
        crs_val = 1;
        fill(20, 3); kick(19); wait_idle();
        check(last_len == 144, "R4", last_len, 144);
        check(done == 1 && irq == 1, "R10", int'({done, irq}), 3);
        check(cs_lost == 0, "R7", int'(cs_lost), 0);
        crs_val = 0;

        // boundary lengths (R3, R4)
        fill(61, 11); kick(59); wait_idle();
        check(last_len == 144, "R4", last_len, 144);
        kick(58); wait_idle();
        check(last_len == 144, "R4", last_len, 144);
        kick(60);
        while (busy) @(negedge clk);
        check(last_len == 146, "R3", last_len, 146);
        // back-to-back: gap must be exactly the minimum (R6)
        kick(19); wait_idle();
        check(last_gap == GAP, "R6", last_gap, GAP);

        // half duplex, carrier follows tx_en (R9 no loss)
        full_duplex = 0; crs_echo = 1;
        fill(70, 5); kick(69); wait_idle();
        check(done == 1 && cs_lost == 0, "R9", int'({done, cs_lost}), 2);

        // half duplex, carrier lost mid-frame (R9)
        drop_at = 60; kick(69); wait_idle();
        check(cs_lost == 1, "R9", int'(cs_lost), 1);
        check(last_len == 164, "R9", last_len, 164);
        drop_at = 0;

        // deferral while carrier busy (R6)
        crs_echo = 0; crs_val = 1;
        kick(19);
        repeat (40) @(negedge clk);
        check(tx_en == 0 && busy == 1, "R6", int'({tx_en, busy}), 1);
        crs_val = 0;
        wait_idle();
        check(done == 1, "R6", int'(done), 1);
        check(last_gap >= GAP, "R6", last_gap, GAP);

        // half duplex collision (R8)
        crs_echo = 1; col_at = 30;
        kick(69);
        while (busy) @(negedge clk);
        check(aborted == 1 && done == 0, "R8", int'({aborted, done}), 2);
        check(last_len < 40, "R8", last_len, 31);
        col_at = 0;
        repeat (5) @(negedge clk);

        // full duplex ignores collision; start clears abort flag (R8, R10)
        full_duplex = 1; crs_echo = 0; col_at = 30;
        kick(19);
        check(aborted == 0, "R10", int'(aborted), 0);
        wait_idle();
        check(aborted == 0 && done == 1, "R8", int'({aborted, done}), 1);
        check(last_len == 144, "R8", last_len, 144);
        col_at = 0;

        // start while busy is ignored (R11)
        kick(19);
        repeat (50) @(negedge clk);
        kick(99);
        wait_idle();
        check(last_len == 144, "R11", last_len, 144);
        repeat (40) @(negedge clk);
        check(busy == 0 && tx_en == 0, "R11", int'({busy, tx_en}), 0);

        // interrupt enable gating (R10)
        irq_en = 0;
        kick(19); wait_idle();
        check(done == 1 && irq == 0, "R10", int'({done, irq}), 2);
        irq_en = 1;
        @(negedge clk);
        check(irq == 1, "R10", int'(irq), 1);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule